// File: doc/BRIEF.md
# Segment Row Latch with Display Modifiers

This block holds one row of segment data for a whole common period and presents it to the segment drivers. A display controller fetches a row from display memory and places it on the row bus. It then pulses the load strobe once per common period. The block captures the row, and at the same edge it samples three display-mode controls: blank (display off), all-on and invert.

The modes act only on the latched copy, on its way to the outputs. Display memory is never read back or written. The block has no path towards memory, so blanking, inverting or lighting every pixel leaves the stored image unchanged. When the mode is cleared, the next loaded row appears exactly as stored.

The mode controls are registered together with the row. A change in the middle of a row therefore never reaches the segments until the next strobe. The modes have a fixed priority: blank first, then all-on, then invert, then plain data.

Top module: `dlm_row_latch`

## Requirements
- R1: On a clock edge with `row_load` high, all `ROW_W` bits of `row_in` are captured, and from that edge onward they drive `seg_out` according to the captured mode.
- R2: Between strobes, `seg_out` holds its value whatever `row_in` does.
- R3: `mode_blank`, `mode_all_on` and `mode_invert` are sampled only on a strobe edge; changing them without a strobe leaves `seg_out` unchanged.
- R4: With blank captured (1), every `seg_out` bit is 0 (segment off), whatever the row, all-on or invert.
- R5: With all-on captured and blank clear, every `seg_out` bit is 1 (segment active); invert has no effect.
- R6: With only invert captured, `seg_out` is the bitwise complement of the captured row.
- R7: With no mode captured, `seg_out` equals the captured row bit for bit (bit i of `row_in` drives bit i of `seg_out`).
- R8: After reset, and until the first strobe, the latched row is zero, blank is in force and `seg_out` is all 0.
- R9: Modes leave no residue: a row loaded with all modes clear after any earlier mode shows exactly that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_in | input | ROW_W | Row data fetched from display memory |
| row_load | input | 1 | Strobe, one per common period, that captures the row and modes |
| mode_blank | input | 1 | 1 = display off |
| mode_all_on | input | 1 | 1 = every segment active |
| mode_invert | input | 1 | 1 = reversed image |
| seg_out | output | ROW_W | Segment data to the drivers, 1 = active |

## Verification
On an 8-bit row, every possible row value is loaded under each of the eight mode combinations. This separates the priority order from any other ordering and catches a stuck or swapped bit lane in the complement and pass-through paths. Holding patterns then change the row bus and the mode inputs without a strobe, which tells apart a registered mode path from a transparent one. A normal row loaded straight after blanked, all-on and inverted rows shows whether an earlier mode leaves any trace.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    typedef struct packed {
        logic blank;
        logic all_on;
        logic invert;
    } dlm_mode_t;

    localparam dlm_mode_t DLM_MODE_RESET = '{blank: 1'b1, all_on: 1'b0, invert: 1'b0};

endpackage

// File: rtl/dlm_row_reg.sv
module dlm_row_reg #(
    parameter int ROW_W = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row_in,
    output logic [ROW_W-1:0] row_q
);

    typedef struct packed {
        logic [ROW_W-1:0] data;
    } row_state_t;

    row_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = row_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_q = st_q.data;

    // R1: a strobe captures the full row bus
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (row_q == $past(row_in)));

    // R2: no strobe, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(row_q));

endmodule

// File: rtl/dlm_mode_reg.sv
module dlm_mode_reg
    import dlm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  dlm_mode_t mode_in,
    output dlm_mode_t mode_q
);

    dlm_mode_t md_d, md_q;

    always_comb begin
        md_d = md_q;
        if (load) begin
            md_d = mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= DLM_MODE_RESET;
        end else begin
            md_q <= md_d;
        end
    end

    assign mode_q = md_q;

    // R3: mode bits move only on a strobe
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));

endmodule

// File: rtl/dlm_seg_mod.sv
module dlm_seg_mod
    import dlm_pkg::*;
#(
    parameter int ROW_W  = 384,
    parameter int LANE_W = 32
) (
    input  dlm_mode_t        mode,
    input  logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] seg
);

    localparam int N_LANES = (ROW_W + LANE_W - 1) / LANE_W;

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        localparam int LO = l * LANE_W;
        localparam int HI = (LO + LANE_W > ROW_W) ? ROW_W - 1 : LO + LANE_W - 1;
        localparam int LW = HI - LO + 1;

        logic [LW-1:0] lane_d;

        always_comb begin
            if (mode.blank) begin
                lane_d = '0;
            end else if (mode.all_on) begin
                lane_d = '1;
            end else if (mode.invert) begin
                lane_d = ~row[HI:LO];
            end else begin
                lane_d = row[HI:LO];
            end
        end

        assign seg[HI:LO] = lane_d;
    end

endmodule

// File: rtl/dlm_row_latch.sv
module dlm_row_latch
    import dlm_pkg::*;
#(
    parameter int ROW_W  = 384,
    parameter int LANE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row_in,
    input  logic             row_load,
    input  logic             mode_blank,
    input  logic             mode_all_on,
    input  logic             mode_invert,
    output logic [ROW_W-1:0] seg_out
);

    dlm_mode_t        mode_in;
    dlm_mode_t        mode_q;
    logic [ROW_W-1:0] row_q;

    assign mode_in = '{blank: mode_blank, all_on: mode_all_on, invert: mode_invert};

    dlm_row_reg #(.ROW_W(ROW_W)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (row_load),
        .row_in (row_in),
        .row_q  (row_q)
    );

    dlm_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (row_load),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    dlm_seg_mod #(.ROW_W(ROW_W), .LANE_W(LANE_W)) u_mod (
        .mode (mode_q),
        .row  (row_q),
        .seg  (seg_out)
    );

    // R4: a blanked strobe turns every segment off
    p_blank_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && mode_blank) |=> (seg_out == '0));

    // R5: all-on without blank lights every segment
    p_all_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && !mode_blank && mode_all_on) |=> (&seg_out));

    // R6: invert only gives the complement of the loaded row
    p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && !mode_blank && !mode_all_on && mode_invert)
            |=> (seg_out == ~$past(row_in)));

    // R7: no mode passes the loaded row straight through
    p_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && !mode_blank && !mode_all_on && !mode_invert)
            |=> (seg_out == $past(row_in)));

    // R2: outputs stay put between strobes
    p_seg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !row_load |=> $stable(seg_out));

endmodule

// File: tb/sim_dlm_row_latch.sv
module sim_dlm_row_latch;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] row_in = '0;
    logic         row_load = 1'b0;
    logic         m_blank = 1'b0;
    logic         m_all = 1'b0;
    logic         m_inv = 1'b0;
    logic [W-1:0] seg_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dlm_row_latch #(.ROW_W(W), .LANE_W(3)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_in      (row_in),
        .row_load    (row_load),
        .mode_blank  (m_blank),
        .mode_all_on (m_all),
        .mode_invert (m_inv),
        .seg_out     (seg_out)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] r, input logic [2:0] m);
        if (m[2])      return '0;
        else if (m[1]) return '1;
        else if (m[0]) return ~r;
        else           return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // m = {blank, all_on, invert}
    task automatic strobe(input logic [W-1:0] r, input logic [2:0] m);
        @(negedge clk);
        row_in   = r;
        {m_blank, m_all, m_inv} = m;
        row_load = 1'b1;
        @(negedge clk);
        row_load = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        row_in = 8'hA5;
        m_inv  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 in reset", seg_out, '0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 after reset, no strobe", seg_out, '0);

        // R1 R4 R5 R6 R7: every row under every mode combination
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < (1 << W); r++) begin
                strobe(W'(r), 3'(m));
                chk($sformatf("R1/R4-R7 mode=%0d", m), seg_out, model(W'(r), 3'(m)));
            end
        end

        // R2: row bus changes without a strobe
        strobe(8'h3C, 3'b000);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            row_in = 8'(k * 37 + 1);
            @(negedge clk);
            chk("R2 row hold", seg_out, 8'h3C);
        end

        // R3: mode inputs change without a strobe
        strobe(8'h96, 3'b001);
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            {m_blank, m_all, m_inv} = 3'(m);
            @(negedge clk);
            @(negedge clk);
            chk("R3 mode hold", seg_out, 8'h69);
        end

        // R9: normal row right after each other mode
        for (int m = 1; m < 8; m++) begin
            strobe(8'hF0, 3'(m));
            chk("R9 moded row", seg_out, model(8'hF0, 3'(m)));
            strobe(8'h5A, 3'b000);
            chk("R9 no residue", seg_out, 8'h5A);
        end

        // R8: reset mid-run returns to blank
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 re-reset", seg_out, '0);
        strobe(8'h00, 3'b010);
        chk("R5 after reset", seg_out, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule